// File: doc/BRIEF.md
# Dual-Buffer Ethernet Transmit Controller

This block is the transmit half of a small memory-mapped Ethernet MAC. A host fills one of two packet buffers through a 32-bit word port. It sets a length, then writes a command into that buffer's control word. A single shared engine then does one of two things. It can stream the buffer out as bytes on a valid/ready/last interface toward the MAC datapath. Or, when the command's load bit is set, it copies the first six bytes of the buffer into the station address, which the receive side uses for filtering.

Each buffer has a length word, a global-interrupt-enable word and a control word. The start bit and the load bit of the control word stay set while the operation runs and clear themselves when it finishes. At completion the block can raise a one-cycle interrupt pulse. The engine is a four-state machine:
- IDLE: waiting for a pending command.
- SEND: streaming bytes.
- LOAD: copying the address.
- DONE: retiring the command.

The transitions are:
- IDLE→SEND: a send command with a non-zero length.
- IDLE→LOAD: a load command.
- IDLE→DONE: a send command with zero length.
- SEND→DONE: the final byte is accepted.
- LOAD→DONE: always, after one cycle.
- DONE→IDLE: always, after one cycle.

Top module: `dbtx_ctrl`

## Requirements
- R1: The port takes a 32-bit word address, with byte offset = address×4. Byte offset bit 11 selects the buffer. Words at offsets 0x000–0x7E3 (within each 2 KiB half) are buffer data. The registers are at 0x7F4 (length), 0x7F8 (interrupt enable) and 0x7FC (control). A read returns its word in the cycle after the read strobe, and an unmapped offset reads 0.
- R2: After reset, every register, the station address, tx_valid and irq are 0.
- R3: Control bit 0 is start, bit 1 is load and bit 3 is interrupt enable. Writing control with bit 0=1 and bit 1=0 sends the buffer's frame.
- R4: A send streams bytes in ascending address order, least significant byte of each word first. tx_last is set only on the final byte. tx_data and tx_last hold while tx_ready is low.
- R5: A length above 2020 bytes sends 2020 bytes. A length of 0 sends no byte, yet the command still completes.
- R6: Writing control with bits 0 and 1 both set copies buffer bytes 0..5 into station_mac, with byte 0 in bits 47:40 and byte 5 in bits 7:0. No byte is streamed.
- R7: Bits 0 and 1 of control read back as written until the operation completes, then read 0. All other control bits keep their written value.
- R8: A control write to a buffer whose start bit is set is ignored in full.
- R9: At completion, irq pulses for one cycle if that buffer's control bit 3 is set and bit 31 of buffer 0's enable word is set. Buffer 1's enable word has no effect.
- R10: A command for one buffer written while the engine serves the other is held and executed afterwards. This includes a command written in the very cycle the other completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Word write strobe |
| host_rd_en | input | 1 | Word read strobe |
| host_waddr | input | ADDR_W-2 | Word address (byte offset / 4) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Datapath accepts the byte |
| irq | output | 1 | One-cycle completion interrupt |
| station_mac | output | 48 | Station address for the receive side |

## Verification
Two events can land in the same clock edge: the engine retiring one buffer in DONE, and a host write to a control or enable word. The bench provokes this by starting a short send on buffer 0 and writing buffer 1's command at each of several offsets after it, so that one offset lands exactly on the retirement edge. A write to the buffer being retired also lands in that cycle and must still be ignored. A behavioural model, built on a byte queue and a pending-bit view of the registers, is compared with the stream, the interrupt, the station address and every read on every clock.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_LOAD = 2'd2,
        ST_DONE = 2'd3
    } eng_state_e;

    localparam int CB_START = 0;
    localparam int CB_LOAD  = 1;
    localparam int CB_IEN   = 3;
    localparam int GIE_BIT  = 31;
endpackage

// File: rtl/dbtx_bank.sv
module dbtx_bank #(
    parameter int BUF_WORDS = 505,
    parameter int IDX_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_we,
    input  logic             len_we,
    input  logic             gie_we,
    input  logic             ctrl_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [31:0]      wdata,
    input  logic             done_i,
    input  logic [IDX_W-1:0] eng_idx,
    output logic [31:0]      host_word,
    output logic [31:0]      eng_word,
    output logic [31:0]      head_lo,
    output logic [31:0]      head_hi,
    output logic [31:0]      len_q,
    output logic [31:0]      gie_q,
    output logic [31:0]      ctrl_q
);
    import dbtx_pkg::*;

    logic [31:0] mem [BUF_WORDS];

    always_ff @(posedge clk) begin
        if (data_we) begin
            mem[host_idx] <= wdata;
        end
    end

    assign host_word = mem[host_idx];
    assign eng_word  = mem[eng_idx];
    assign head_lo   = mem[0];
    assign head_hi   = mem[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            gie_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (len_we) len_q <= wdata;
            if (gie_we) gie_q <= wdata;
            if (done_i) begin
                ctrl_q[CB_LOAD:CB_START] <= 2'b00;
            end else if (ctrl_we && !ctrl_q[CB_START]) begin
                ctrl_q <= wdata;
            end
        end
    end
endmodule

// File: rtl/dbtx_engine.sv
module dbtx_engine #(
    parameter int BUF_WORDS = 505,
    parameter int IDX_W     = 9,
    parameter int CNT_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       start_i,
    input  logic [1:0]       load_i,
    input  logic [1:0]       ien_i,
    input  logic             gie_i,
    input  logic [31:0]      len0_i,
    input  logic [31:0]      len1_i,
    input  logic [31:0]      word_i,
    input  logic [31:0]      head_lo_i,
    input  logic [31:0]      head_hi_i,
    input  logic             tx_ready_i,
    output logic             sel_o,
    output logic [IDX_W-1:0] word_idx_o,
    output logic             tx_valid_o,
    output logic [7:0]       tx_data_o,
    output logic             tx_last_o,
    output logic [1:0]       done_o,
    output logic             irq_o,
    output logic [47:0]      mac_o
);
    import dbtx_pkg::*;

    localparam int BUF_BYTES = BUF_WORDS * 4;

    eng_state_e       state_q, state_d;
    logic             sel_q;
    logic [CNT_W-1:0] cnt_q, last_q;
    logic [47:0]      mac_q;
    logic             irq_q;

    logic             pick;
    logic             any_req;
    logic [31:0]      len_pick;
    logic [CNT_W-1:0] last_pick;
    logic             at_last;

    assign pick      = !start_i[0];
    assign any_req   = |start_i;
    assign len_pick  = pick ? len1_i : len0_i;
    assign last_pick = (len_pick > 32'(BUF_BYTES)) ? CNT_W'(BUF_BYTES - 1)
                                                    : CNT_W'(len_pick - 32'd1);
    assign at_last   = (cnt_q == last_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) begin
                    if (load_i[pick])        state_d = ST_LOAD;
                    else if (len_pick == 0)  state_d = ST_DONE;
                    else                     state_d = ST_SEND;
                end
            end
            ST_SEND: if (tx_ready_i && at_last) state_d = ST_DONE;
            ST_LOAD: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
            cnt_q   <= '0;
            last_q  <= '0;
            mac_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= (state_q == ST_DONE) && ien_i[sel_q] && gie_i;
            if (state_q == ST_IDLE && any_req) begin
                sel_q  <= pick;
                cnt_q  <= '0;
                last_q <= last_pick;
            end
            if (state_q == ST_SEND && tx_ready_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_LOAD) begin
                mac_q <= {head_lo_i[7:0], head_lo_i[15:8], head_lo_i[23:16],
                          head_lo_i[31:24], head_hi_i[7:0], head_hi_i[15:8]};
            end
        end
    end

    always_comb begin
        sel_o      = sel_q;
        word_idx_o = cnt_q[CNT_W-1:2];
        tx_valid_o = (state_q == ST_SEND);
        tx_data_o  = word_i[8*cnt_q[1:0] +: 8];
        tx_last_o  = (state_q == ST_SEND) && at_last;
        done_o     = (state_q == ST_DONE) ? (sel_q ? 2'b10 : 2'b01) : 2'b00;
        irq_o      = irq_q;
        mac_o      = mac_q;
    end
endmodule

// File: rtl/dbtx_ctrl.sv
module dbtx_ctrl #(
    parameter int BUF_WORDS = 505,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:2] host_waddr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              irq,
    output logic [47:0]       station_mac
);
    import dbtx_pkg::*;

    localparam int HIDX_W = ADDR_W - 3;
    localparam int IDX_W  = $clog2(BUF_WORDS);
    localparam int CNT_W  = IDX_W + 2;
    localparam logic [HIDX_W-1:0] LEN_IDX  = HIDX_W'((1 << HIDX_W) - 3);
    localparam logic [HIDX_W-1:0] GIE_IDX  = HIDX_W'((1 << HIDX_W) - 2);
    localparam logic [HIDX_W-1:0] CTRL_IDX = HIDX_W'((1 << HIDX_W) - 1);
    localparam logic [HIDX_W-1:0] DATA_END = HIDX_W'(BUF_WORDS);

    logic              bsel;
    logic [HIDX_W-1:0] hidx;
    logic              is_data;
    logic [31:0]       host_word [2];
    logic [31:0]       eng_word  [2];
    logic [31:0]       head_lo   [2];
    logic [31:0]       head_hi   [2];
    logic [31:0]       len_w     [2];
    logic [31:0]       gie_w     [2];
    logic [31:0]       ctrl_w    [2];
    logic [1:0]        done;
    logic              eng_sel;
    logic [IDX_W-1:0]  eng_idx;
    logic              irq_gate;
    logic [31:0]       rdata_q;

    assign bsel     = host_waddr[ADDR_W-1];
    assign hidx     = host_waddr[ADDR_W-2:2];
    assign is_data  = (hidx < DATA_END);
    assign irq_gate = gie_w[0][GIE_BIT];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic here;
        assign here = host_wr_en && (bsel == b[0]);
        dbtx_bank #(.BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .data_we  (here && is_data),
            .len_we   (here && hidx == LEN_IDX),
            .gie_we   (here && hidx == GIE_IDX),
            .ctrl_we  (here && hidx == CTRL_IDX),
            .host_idx (hidx[IDX_W-1:0]),
            .wdata    (host_wdata),
            .done_i   (done[b]),
            .eng_idx  (eng_idx),
            .host_word(host_word[b]),
            .eng_word (eng_word[b]),
            .head_lo  (head_lo[b]),
            .head_hi  (head_hi[b]),
            .len_q    (len_w[b]),
            .gie_q    (gie_w[b]),
            .ctrl_q   (ctrl_w[b])
        );
    end

    dbtx_engine #(.BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   ({ctrl_w[1][CB_START], ctrl_w[0][CB_START]}),
        .load_i    ({ctrl_w[1][CB_LOAD],  ctrl_w[0][CB_LOAD]}),
        .ien_i     ({ctrl_w[1][CB_IEN],   ctrl_w[0][CB_IEN]}),
        .gie_i     (irq_gate),
        .len0_i    (len_w[0]),
        .len1_i    (len_w[1]),
        .word_i    (eng_word[eng_sel]),
        .head_lo_i (head_lo[eng_sel]),
        .head_hi_i (head_hi[eng_sel]),
        .tx_ready_i(tx_ready),
        .sel_o     (eng_sel),
        .word_idx_o(eng_idx),
        .tx_valid_o(tx_valid),
        .tx_data_o (tx_data),
        .tx_last_o (tx_last),
        .done_o    (done),
        .irq_o     (irq),
        .mac_o     (station_mac)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (host_rd_en) begin
            if (is_data)                rdata_q <= host_word[bsel];
            else if (hidx == LEN_IDX)   rdata_q <= len_w[bsel];
            else if (hidx == GIE_IDX)   rdata_q <= gie_w[bsel];
            else if (hidx == CTRL_IDX)  rdata_q <= ctrl_w[bsel];
            else                        rdata_q <= '0;
        end
    end

    assign host_rdata = rdata_q;
endmodule

// File: rtl/dbtx_ctrl_chk.sv
module dbtx_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_valid,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        tx_ready,
    input logic        irq,
    input logic        irq_gate,
    input logic [1:0]  done,
    input logic [47:0] station_mac
);
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);                                           // R4
    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                   // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_gate));                                        // R9
    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(done != 2'b00));                                   // R9
    AST_MAC_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(station_mac) |-> !tx_valid);                            // R6
    AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));                                                 // R10
endmodule

bind dbtx_ctrl dbtx_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .tx_ready   (tx_ready),
    .irq        (irq),
    .irq_gate   (irq_gate),
    .done       (done),
    .station_mac(station_mac)
);

// File: tb/dbtx_ctrl_tb_top.sv
module dbtx_ctrl_tb_top;
    localparam int BW = 505;
    localparam int MAXB = BW * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:2] waddr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tx_valid, tx_last, irq;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic [47:0] mac;

    always #2.5 clk = ~clk;

    dbtx_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(wr_en), .host_rd_en(rd_en),
        .host_waddr(waddr), .host_wdata(wdata), .host_rdata(rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .irq(irq), .station_mac(mac)
    );

    // behavioural reference
    logic [31:0] smem [2][BW];
    logic [31:0] m_len [2], m_gie [2], m_ctrl [2];
    logic [47:0] m_mac;
    logic        m_irq;
    logic [31:0] m_rd;
    int          m_ph;   // 0 idle, 1 streaming, 2 address load, 3 retiring
    int          m_sel;
    byte unsigned m_q[$];

    int    vectors = 0, miscompares = 0, cycles = 0;
    string cur_req = "R2";
    bit    stall = 1'b0;

    function automatic logic [31:0] m_read(input logic [11:2] a);
        int b = int'(a[11]);
        int i = int'(a[10:2]);
        if (i < BW)  return smem[b][i];
        if (i == 509) return m_len[b];
        if (i == 510) return m_gie[b];
        if (i == 511) return m_ctrl[b];
        return 32'h0;
    endfunction

    always @(posedge clk) begin : mdl
        logic s_pre [2];
        logic n_irq;
        int   n;
        if (!rst_n) begin
            m_len = '{0, 0}; m_gie = '{0, 0}; m_ctrl = '{0, 0};
            m_mac = '0; m_irq = 1'b0; m_rd = '0; m_ph = 0; m_sel = 0;
            m_q.delete();
        end else begin
            s_pre[0] = m_ctrl[0][0];
            s_pre[1] = m_ctrl[1][0];
            if (rd_en) m_rd = m_read(waddr);
            n_irq = (m_ph == 3) && m_ctrl[m_sel][3] && m_gie[0][31];
            case (m_ph)
                0: if (m_ctrl[0][0] || m_ctrl[1][0]) begin
                    m_sel = m_ctrl[0][0] ? 0 : 1;
                    if (m_ctrl[m_sel][1]) m_ph = 2;
                    else begin
                        n = (m_len[m_sel] > MAXB) ? MAXB : int'(m_len[m_sel]);
                        m_q.delete();
                        for (int k = 0; k < n; k++)
                            m_q.push_back(smem[m_sel][k / 4][8 * (k % 4) +: 8]);
                        m_ph = (n == 0) ? 3 : 1;
                    end
                end
                1: if (tx_ready) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_ph = 3;
                end
                2: begin
                    m_mac = {smem[m_sel][0][7:0], smem[m_sel][0][15:8],
                             smem[m_sel][0][23:16], smem[m_sel][0][31:24],
                             smem[m_sel][1][7:0], smem[m_sel][1][15:8]};
                    m_ph = 3;
                end
                default: begin
                    m_ctrl[m_sel][1:0] = 2'b00;
                    m_ph = 0;
                end
            endcase
            m_irq = n_irq;
            if (wr_en) begin
                if (int'(waddr[10:2]) < BW) smem[waddr[11]][waddr[10:2]] = wdata;
                else if (waddr[10:2] == 9'd509) m_len[waddr[11]] = wdata;
                else if (waddr[10:2] == 9'd510) m_gie[waddr[11]] = wdata;
                else if (waddr[10:2] == 9'd511 && !s_pre[waddr[11]]) m_ctrl[waddr[11]] = wdata;
            end
        end
    end

    task automatic miss(input string what, input logic [63:0] act, input logic [63:0] exp);
        miscompares++;
        $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (tx_valid !== (m_ph == 1)) miss("tx_valid", 64'(tx_valid), 64'(m_ph == 1));
            else if (m_ph == 1) begin
                if (tx_data !== m_q[0]) miss("tx_data", 64'(tx_data), 64'(m_q[0]));
                if (tx_last !== (m_q.size() == 1)) miss("tx_last", 64'(tx_last), 64'(m_q.size() == 1));
            end
            if (irq !== m_irq) miss("irq", 64'(irq), 64'(m_irq));
            if (mac !== m_mac) miss("station_mac", 64'(mac), 64'(m_mac));
            if (rdata !== m_rd) miss("rdata", 64'(rdata), 64'(m_rd));
            tx_ready = stall ? ((cycles % 3) != 1) : 1'b1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            miscompares++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; waddr = 10'(a >> 2); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a);
        rd_en = 1'b1; waddr = 10'(a >> 2);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic settle();
        for (int i = 0; i < 4000; i++) begin
            if (m_ph == 0 && !m_ctrl[0][0] && !m_ctrl[1][0]) break;
            @(negedge clk);
        end
        idle(2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R2: reset state
        cur_req = "R2";
        idle(2);
        rd(12'h7F4); rd(12'h7F8); rd(12'h7FC); rd(12'hFFC);
        // R1: buffer fill and map
        cur_req = "R1";
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < BW; k++)
                wr(b * 12'h800 + k * 4, (32'(b) << 28) ^ (32'(k) * 32'h0001_0203) ^ 32'h1122_3344);
        rd(12'h000); rd(12'h004); rd(12'h7E0); rd(12'h800); rd(12'hFE0);
        rd(12'h7E4); rd(12'hFEC); rd(12'h7F0);
        wr(12'hFF4, 32'h55); rd(12'hFF4); rd(12'h7F4);
        // R3, R4, R7: send with backpressure, read control while busy
        cur_req = "R4";
        wr(12'h7F8, 32'h8000_0000);
        wr(12'h7F4, 32'd7);
        stall = 1'b1;
        cur_req = "R3";
        wr(12'h7FC, 32'h0000_00F9);
        cur_req = "R7";
        rd(12'h7FC);
        settle();
        rd(12'h7FC);
        stall = 1'b0;
        // R8: command ignored while busy
        cur_req = "R8";
        wr(12'h7F4, 32'd40);
        wr(12'h7FC, 32'h9);
        wr(12'h7FC, 32'h0B);
        rd(12'h7FC);
        settle();
        rd(12'h7FC);
        // R6: address load from buffer 1, with and without interrupt
        cur_req = "R6";
        wr(12'hFFC, 32'h3);
        rd(12'hFFC);
        settle();
        wr(12'h804, 32'hDEAD_BEEF);
        wr(12'hFFC, 32'hB);
        settle();
        rd(12'hFFC);
        // R9: interrupt gating by buffer 0 enable only
        cur_req = "R9";
        wr(12'h7F8, 32'h7FFF_FFFF);
        wr(12'hFF8, 32'h8000_0000);
        wr(12'h7F4, 32'd3);
        wr(12'h7FC, 32'h9);
        settle();
        wr(12'hFF4, 32'd2);
        wr(12'hFFC, 32'h9);
        settle();
        wr(12'h7F8, 32'h8000_0000);
        wr(12'hFFC, 32'h9);
        settle();
        // R5: zero length and clamp
        cur_req = "R5";
        wr(12'h7F4, 32'd0);
        wr(12'h7FC, 32'h9);
        settle();
        wr(12'hFF4, 32'd5000);
        wr(12'hFFC, 32'h9);
        settle();
        stall = 1'b1;
        wr(12'hFF4, 32'd2021);
        wr(12'hFFC, 32'h1);
        settle();
        stall = 1'b0;
        // R10: command for the other buffer around the retirement cycle
        cur_req = "R10";
        for (int off = 0; off < 8; off++) begin
            wr(12'h7F4, 32'd3);
            wr(12'hFF4, 32'd2);
            wr(12'h7FC, 32'h9);
            idle(off);
            wr(12'hFFC, 32'h9);
            wr(12'h7FC, 32'h1);
            settle();
        end
        for (int off = 0; off < 5; off++) begin
            wr(12'h7F4, 32'd2);
            wr(12'h7FC, 32'h9);
            idle(off);
            wr(12'h7F8, 32'h0);
            wr(12'h7F8, 32'h8000_0000);
            settle();
        end
        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule